// File: doc/BRIEF.md
# Tuning Reference Divider and Phase-Frequency Comparator

This block is the digital core of a frequency-synthesizer tuning loop. It divides the crystal clock down to a comparison reference. The division ratio is 512 or 1024, picked by a two-bit select. It compares that reference with the feedback from the programmable divider in a phase-and-frequency detector. The detector's up/down decisions become charge-pump enables. Control inputs can force one pump source on, or float the pump output. Two other control inputs are passed on as flags: the pump current select and the amplifier disable.

A lock monitor watches how wide the detector's pulses are and raises a lock flag after a run of clean reference periods. The block also drives four band-switch pins with the right polarity. In test mode it can route the reference square wave and the feedback divided by two onto two of those pins, so the internal frequencies can be measured from outside.

All logic runs on the crystal clock. The feedback input is a level that is already synchronous to that clock. Its rising edges are the feedback events.

Top module: `tune_pfd_core`

## Requirements
- R1: The reference period is 512 clocks when ref_sel is 00 or 11 and 1024 clocks when it is 01 or 10; the first reference event falls 512 clocks after reset. The reference square wave is high for the first half of each period.
- R2: The detector is frequency sensitive. If reference events arrive with no feedback edge between them, pump_up stays asserted across them. The same holds for pump_dn when feedback edges arrive with no reference event.
- R3: A reference event sets the up flag and a feedback rising edge sets the down flag, each one clock later. When both flags are set they clear after exactly one clock. In normal mode, pump_up is the up flag without the down flag, and pump_dn is the reverse. Coincident events therefore produce no pump pulse.
- R4: pump_mode[1:0] selects the pump drive. 10 gives normal detector operation. 00 forces pump_up=1 and pump_dn=0. 01 forces pump_dn=1 and pump_up=0. 11 drives both low with pump_oe=0. pump_oe is 1 in every other mode.
- R5: pump_hi_cur equals pump_hi_sel (1 selects the high pump current), and amp_disable equals amp_off. Both change in the same cycle as their input.
- R6: lock goes to 1 one clock after the 16th reference event counted since reset or since the last excess pulse.
- R7: If the up flag alone or the down flag alone stays set for two consecutive clocks, this is an excess pulse. The lock count returns to zero, and lock reads 0 from the next clock.
- R8: band_out[0], band_out[1] and band_out[2] equal band_bits[0], band_bits[1] and band_bits[2]. band_out[3] is the inverse of band_bits[3].
- R9: While test_route=1, band_out[2] shows the reference square wave if band_bits[2]=1, and band_out[1] shows a feedback divide-by-two if band_bits[1]=1. The divide-by-two is reset to 0 and toggles one clock after each feedback rising edge. A pin whose band bit is 0 keeps its R8 function.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crystal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fb_in | input | 1 | Programmable divider output, synchronous level |
| ref_sel | input | 2 | Reference ratio select |
| pump_mode | input | 2 | Pump drive mode |
| pump_hi_sel | input | 1 | High pump current request |
| amp_off | input | 1 | Amplifier off request |
| test_route | input | 1 | Frequency routing test mode |
| band_bits | input | 4 | Band control bits {b3,b2,b1,b0} |
| pump_up | output | 1 | Upper pump source enable |
| pump_dn | output | 1 | Lower pump source enable |
| pump_oe | output | 1 | Pump output drive enable |
| pump_hi_cur | output | 1 | Pump current select flag |
| amp_disable | output | 1 | Amplifier disable flag |
| lock | output | 1 | Loop lock flag |
| band_out | output | 4 | Band pin levels |

## Verification
The assertions take for granted that fb_in is already synchronous to clk and that reset is low from time zero. Reset-pulse timing, reference spacing, lock rise and lock drop are then all defined from the first clock edge. The stimulus drives fb_in at falling edges as a one-clock pulse placed a chosen number of clocks before or after each reference event, or holds it low. This yields clean, marginal, excessive and missing feedback against both reference ratios.

// File: rtl/tune_pkg.sv
package tune_pkg;

  typedef enum logic [1:0] {
    PM_SRC_UP = 2'b00,
    PM_SRC_DN = 2'b01,
    PM_NORMAL = 2'b10,
    PM_HIZ    = 2'b11
  } pump_mode_e;

  // Odd parity of the select doubles the base reference ratio.
  function automatic logic ratio_doubled(input logic [1:0] sel);
    return sel[1] ^ sel[0];
  endfunction

endpackage

// File: rtl/ref_divider.sv
module ref_divider #(
  parameter int BASE_DIV = 512
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] ratio_sel,
  output logic       tick,
  output logic       level
);
  import tune_pkg::*;

  localparam int CW = $clog2(2 * BASE_DIV);
  localparam int RW = CW + 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic [RW-1:0] ratio;
  logic [RW-1:0] cnt_ext;

  always_comb begin
    ratio   = ratio_doubled(ratio_sel) ? RW'(2 * BASE_DIV) : RW'(BASE_DIV);
    cnt_ext = {1'b0, cnt_q};
    // wrap also catches a count left above a newly shortened ratio
    tick    = (cnt_ext >= (ratio - RW'(1)));
    level   = (cnt_ext < (ratio >> 1));
    cnt_d   = tick ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/pfd_core.sv
module pfd_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ref_tick,
  input  logic       fb_in,
  input  logic [1:0] mode,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_oe,
  output logic       up_flag,
  output logic       dn_flag,
  output logic       fb_tick,
  output logic       fb_half,
  output logic       excess
);
  import tune_pkg::*;

  logic fb_prev_q, fb_half_q, fb_half_d;
  logic up_q, up_d, dn_q, dn_d;
  logic up_run_q, dn_run_q;
  logic both, up_only, dn_only;
  pump_mode_e pm;

  always_comb begin
    fb_tick   = fb_in & ~fb_prev_q;
    both      = up_q & dn_q;
    // coincident new event during the clearing cycle is kept
    up_d      = both ? ref_tick : (up_q | ref_tick);
    dn_d      = both ? fb_tick  : (dn_q | fb_tick);
    up_only   = up_q & ~dn_q;
    dn_only   = dn_q & ~up_q;
    excess    = (up_only & up_run_q) | (dn_only & dn_run_q);
    fb_half_d = fb_tick ? ~fb_half_q : fb_half_q;
  end

  always_comb begin
    pm      = pump_mode_e'(mode);
    pump_oe = 1'b1;
    pump_up = 1'b0;
    pump_dn = 1'b0;
    case (pm)
      PM_SRC_UP: pump_up = 1'b1;
      PM_SRC_DN: pump_dn = 1'b1;
      PM_NORMAL: begin
        pump_up = up_only;
        pump_dn = dn_only;
      end
      default:   pump_oe = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fb_prev_q <= 1'b0;
      fb_half_q <= 1'b0;
      up_q      <= 1'b0;
      dn_q      <= 1'b0;
      up_run_q  <= 1'b0;
      dn_run_q  <= 1'b0;
    end else begin
      fb_prev_q <= fb_in;
      fb_half_q <= fb_half_d;
      up_q      <= up_d;
      dn_q      <= dn_d;
      up_run_q  <= up_only;
      dn_run_q  <= dn_only;
    end
  end

  assign up_flag = up_q;
  assign dn_flag = dn_q;
  assign fb_half = fb_half_q;

endmodule

// File: rtl/lock_monitor.sv
module lock_monitor #(
  parameter int LOCK_PERIODS = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_tick,
  input  logic excess,
  output logic lock
);
  localparam int LW = $clog2(LOCK_PERIODS + 1);
  localparam logic [LW-1:0] FULL = LW'(LOCK_PERIODS);

  logic [LW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = ref_tick && (cnt_q != FULL);
    if (excess)      cnt_d = '0;
    else if (cnt_en) cnt_d = cnt_q + LW'(1);
    else             cnt_d = cnt_q;
    lock = (cnt_q == FULL);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/band_driver.sv
module band_driver (
  input  logic [3:0] band_bits,
  input  logic       test_en,
  input  logic       ref_level,
  input  logic       fb_half,
  output logic [3:0] band_out
);
  always_comb begin
    band_out[0] = band_bits[0];
    band_out[1] = (test_en && band_bits[1]) ? fb_half   : band_bits[1];
    band_out[2] = (test_en && band_bits[2]) ? ref_level : band_bits[2];
    band_out[3] = ~band_bits[3];   // sinking driver: on pulls low
  end
endmodule

// File: rtl/tune_pfd_core.sv
module tune_pfd_core #(
  parameter int BASE_DIV     = 512,
  parameter int LOCK_PERIODS = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       fb_in,
  input  logic [1:0] ref_sel,
  input  logic [1:0] pump_mode,
  input  logic       pump_hi_sel,
  input  logic       amp_off,
  input  logic       test_route,
  input  logic [3:0] band_bits,
  output logic       pump_up,
  output logic       pump_dn,
  output logic       pump_oe,
  output logic       pump_hi_cur,
  output logic       amp_disable,
  output logic       lock,
  output logic [3:0] band_out
);
  logic ref_tick, ref_level;
  logic pfd_up, pfd_dn, pfd_err;
  logic fb_tick, fb_half;

  ref_divider #(.BASE_DIV(BASE_DIV)) u_ref (
    .clk(clk), .rst_n(rst_n), .ratio_sel(ref_sel),
    .tick(ref_tick), .level(ref_level)
  );

  pfd_core u_pfd (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .fb_in(fb_in),
    .mode(pump_mode), .pump_up(pump_up), .pump_dn(pump_dn),
    .pump_oe(pump_oe), .up_flag(pfd_up), .dn_flag(pfd_dn),
    .fb_tick(fb_tick), .fb_half(fb_half), .excess(pfd_err)
  );

  lock_monitor #(.LOCK_PERIODS(LOCK_PERIODS)) u_lock (
    .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick),
    .excess(pfd_err), .lock(lock)
  );

  band_driver u_band (
    .band_bits(band_bits), .test_en(test_route), .ref_level(ref_level),
    .fb_half(fb_half), .band_out(band_out)
  );

  assign pump_hi_cur = pump_hi_sel;
  assign amp_disable = amp_off;

endmodule

// File: rtl/tune_pfd_checker.sv
module tune_pfd_checker (
  input logic clk,
  input logic rst_n,
  input logic ref_tick,
  input logic pfd_up,
  input logic pfd_dn,
  input logic pfd_err,
  input logic fb_tick,
  input logic fb_half,
  input logic lock
);
  // R1: reference events are never on adjacent clocks
  assert_ref_spacing_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ref_tick |=> !ref_tick);

  // R3: the both-set state lasts a single clock
  assert_reset_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (pfd_up && pfd_dn) |=> !(pfd_up && pfd_dn));

  // R6: lock only rises right after a reference event
  assert_lock_rise_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lock) |-> $past(ref_tick));

  // R7: an excess pulse removes lock on the next clock
  assert_lock_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pfd_err |=> !lock);

  // R9: the feedback halver flips after every feedback edge
  assert_fb_toggle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fb_tick |=> (fb_half != $past(fb_half)));
endmodule

bind tune_pfd_core tune_pfd_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ref_tick(ref_tick), .pfd_up(pfd_up),
  .pfd_dn(pfd_dn), .pfd_err(pfd_err), .fb_tick(fb_tick),
  .fb_half(fb_half), .lock(lock)
);

// File: tb/sim_tune_pfd_core.sv
module sim_tune_pfd_core;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       fb_in = 1'b0;
  logic [1:0] ref_sel = 2'b00;
  logic [1:0] pump_mode = 2'b10;
  logic       pump_hi_sel = 1'b0;
  logic       amp_off = 1'b0;
  logic       test_route = 1'b0;
  logic [3:0] band_bits = 4'b0000;
  logic       pump_up, pump_dn, pump_oe, pump_hi_cur, amp_disable, lock;
  logic [3:0] band_out;

  tune_pfd_core u0 (
    .clk(clk), .rst_n(rst_n), .fb_in(fb_in), .ref_sel(ref_sel),
    .pump_mode(pump_mode), .pump_hi_sel(pump_hi_sel), .amp_off(amp_off),
    .test_route(test_route), .band_bits(band_bits), .pump_up(pump_up),
    .pump_dn(pump_dn), .pump_oe(pump_oe), .pump_hi_cur(pump_hi_cur),
    .amp_disable(amp_disable), .lock(lock), .band_out(band_out)
  );

  always #4 clk = ~clk;

  int tests = 0;
  int fails = 0;
  bit done = 0;
  string ptag = "R3";
  string ltag = "R6";

  // behavioural reference state
  int m_cnt, m_lk;
  bit m_fbp, m_half, m_up, m_dn, m_wu, m_wd;

  function automatic int cur_ratio();
    return (ref_sel == 2'b01 || ref_sel == 2'b10) ? 1024 : 512;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 0; m_lk = 0; m_fbp = 0; m_half = 0;
      m_up = 0; m_dn = 0; m_wu = 0; m_wd = 0;
    end else begin
      int r;
      bit rt, ft, bad, nu, nd;
      r   = cur_ratio();
      rt  = (m_cnt >= r - 1);
      ft  = fb_in && !m_fbp;
      bad = (m_up && !m_dn && m_wu) || (m_dn && !m_up && m_wd);
      if (m_up && m_dn) begin nu = rt; nd = ft; end
      else begin nu = m_up || rt; nd = m_dn || ft; end
      m_wu = m_up && !m_dn;
      m_wd = m_dn && !m_up;
      m_up = nu; m_dn = nd;
      if (ft) m_half = !m_half;
      m_fbp = fb_in;
      m_cnt = rt ? 0 : m_cnt + 1;
      if (bad) m_lk = 0;
      else if (rt && m_lk < 16) m_lk = m_lk + 1;
    end
  end

  task automatic check(input string tag, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic check_all();
    bit eu, ed, eo, lvl;
    eu = 0; ed = 0; eo = 1;
    case (pump_mode)
      2'b00: eu = 1;
      2'b01: ed = 1;
      2'b10: begin eu = m_up && !m_dn; ed = m_dn && !m_up; end
      default: eo = 0;
    endcase
    lvl = (m_cnt < cur_ratio() / 2);
    check(ptag, "pump_up", pump_up, eu);
    check(ptag, "pump_dn", pump_dn, ed);
    check("R4", "pump_oe", pump_oe, eo);
    check("R5", "pump_hi_cur", pump_hi_cur, pump_hi_sel);
    check("R5", "amp_disable", amp_disable, amp_off);
    check(ltag, "lock", lock, (m_lk == 16));
    check("R8", "band0", band_out[0], band_bits[0]);
    check("R8", "band3", band_out[3], !band_bits[3]);
    if (test_route && band_bits[1]) check("R9", "band1_fbhalf", band_out[1], m_half);
    else                            check("R8", "band1", band_out[1], band_bits[1]);
    if (test_route && band_bits[2]) check("R1", "band2_ref", band_out[2], lvl);
    else                            check("R8", "band2", band_out[2], band_bits[2]);
  endtask

  // run n clocks; feedback pulse k clocks after each reference event
  task automatic run(input int n, input int k, input bit use_fb);
    for (int i = 0; i < n; i++) begin
      int r, tgt;
      @(negedge clk);
      check_all();
      r   = cur_ratio();
      tgt = (((r - 1 + k) % r) + r) % r;
      fb_in = use_fb && (m_cnt == tgt);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog expired");
    if (!done) begin
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    // reset state
    check("R6", "reset_lock", lock, 0);
    check("R3", "reset_pump_up", pump_up, 0);
    check("R8", "reset_band", band_out, 4'b1000);
    rst_n = 1'b1;

    // aligned feedback: lock after 16 clean periods
    ptag = "R3"; ltag = "R6";
    run(512 * 20, 0, 1);
    check("R6", "lock_aligned", lock, 1);

    // three clocks late: excess pulse
    ltag = "R7";
    run(512 * 4, 3, 1);
    check("R7", "lock_lost_late", lock, 0);

    // one clock late is within tolerance
    ltag = "R6";
    run(512 * 20, 1, 1);
    check("R6", "lock_one_late", lock, 1);

    // two clocks early
    ltag = "R7";
    run(512 * 3, -2, 1);
    check("R7", "lock_lost_early", lock, 0);

    // missing feedback: frequency error
    ptag = "R2";
    run(512 * 3, 0, 0);
    check("R2", "up_held", pump_up, 1);

    // forced and floating modes plus flags
    ptag = "R4"; ltag = "R6";
    pump_mode = 2'b00; pump_hi_sel = 1'b1; run(300, 0, 1);
    pump_mode = 2'b01; amp_off = 1'b1;     run(300, 0, 1);
    pump_mode = 2'b11; pump_hi_sel = 1'b0; run(300, 0, 1);
    check("R4", "hiz_oe", pump_oe, 0);
    pump_mode = 2'b10; amp_off = 1'b0;
    ptag = "R3";

    // doubled ratio with test routing
    ref_sel = 2'b01; test_route = 1'b1; band_bits = 4'b0111;
    run(1024 * 4, 0, 1);
    ref_sel = 2'b10; run(1024 * 2, 5, 1);
    band_bits = 4'b1001; run(1024, 0, 1);
    check("R8", "test_off_bits", band_out[2:1], 2'b00);
    ref_sel = 2'b11; band_bits = 4'b0110; run(512 * 2, 0, 1);
    test_route = 1'b0; run(600, 0, 1);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule